// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts where subroutine returns will go, so the fetch pipeline can follow a return before execution has read the real return address from memory. A call pushes its return PC onto a small hidden stack of four entries. When the prefetch stream meets a return, the block pops the top entry. If that entry is valid, the block offers it as the new fetch address in the same cycle. Software has no way to read or write the stack.

Later, execution presents the real return address that it loaded from the stack in memory. The block compares that address with the prediction it made for the most recent return and reports one of three outcomes. Each outcome has a fixed cycle cost. A correct prediction needs no redirect. A return with no prediction needs a redirect to the memory address. A wrong prediction needs an abort followed by a redirect. A push onto a full stack overwrites the oldest entry, so the stack always holds the four most recent return PCs.

Top module: `ras_predictor`

## Requirements
- R1: Reset is a synchronous, active-high input. It clears every entry's valid bit and all result outputs. A return fetched after reset, with no call in between, gives `pred_hit`=0.
- R2: After a call, a return fetched in the next cycle gives `pred_hit`=1 and `pred_target` equal to that call's PC. `pred_hit` and `pred_target` are combinational and appear in the same cycle as `ret_fetch`.
- R3: Return PCs come back last-in-first-out. After calls with A, B and C, three returns predict C, then B, then A.
- R4: A fifth push onto a full stack discards the oldest entry. After five calls, four returns predict the last four PCs, newest first, and a fifth return gives `pred_hit`=0.
- R5: A return fetched on an empty stack gives `pred_hit`=0 and leaves the stack unchanged. A following call and return still predict that call's PC, and the return after that gives `pred_hit`=0.
- R6: When a call and a return occur in the same cycle, the prediction is the old top entry. The call's PC then replaces that top entry, so the stack depth is unchanged.
- R7: One cycle after `verify_valid`, `res_valid` is 1 for exactly one cycle. If the last return was predicted and the address matches, `res_kind`=0 (correct), `res_cost`=2, and `res_redirect`=0 and `res_abort`=0.
- R8: If the last return was not predicted, or no return has been fetched since the last verify, the result is `res_kind`=1 (unpredicted) with `res_cost`=8, `res_redirect`=1, `res_abort`=0, and `res_target` equal to the verified address.
- R9: If the last return was predicted and the address differs, the result is `res_kind`=2 (mispredicted) with `res_cost`=9, `res_abort`=1, `res_redirect`=1, and `res_target` equal to the verified address.
- R10: When a verify and a call occur in the same cycle, the verify is judged first, against the prediction made earlier. The call's PC is still pushed and becomes the next prediction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_valid | input | 1 | A subroutine call executes; push `call_pc` |
| call_pc | input | AW | Return PC of the call |
| ret_fetch | input | 1 | A return is seen in the prefetch stream; pop |
| pred_hit | output | 1 | The return was predicted (top entry valid) |
| pred_target | output | AW | Predicted fetch address |
| verify_valid | input | 1 | Execution presents the real return address |
| verify_addr | input | AW | Return address read from the memory stack |
| res_valid | output | 1 | Verification result is present this cycle |
| res_kind | output | 2 | 0 correct, 1 unpredicted, 2 mispredicted |
| res_cost | output | 4 | Cycle cost of the return: 2, 8 or 9 |
| res_redirect | output | 1 | Restart fetch at `res_target` |
| res_abort | output | 1 | Abort work done on the wrong path |
| res_target | output | AW | Address from the memory stack |

## Verification
Two pairs of functions can land in the same clock edge. The first pair is a call and a return: the stack must then predict from the old top and leave the new PC in its place. The second pair is a call and the verify of an earlier return: that return must be judged against its recorded prediction, not against the PC being pushed. The stimulus table drives each pair in one row. The rows that follow check that the next prediction is the newly pushed PC, and that the result reports the outcome of the older prediction with its cost, redirect and abort.

// File: rtl/ras_pkg.sv
package ras_pkg;

    localparam int RAS_COST_W = 4;

    typedef enum logic [1:0] {
        RET_CORRECT = 2'd0,
        RET_UNPRED  = 2'd1,
        RET_MISPRED = 2'd2
    } ret_kind_e;

    typedef struct packed {
        ret_kind_e              kind;
        logic [RAS_COST_W-1:0]  cost;
        logic                   redirect;
        logic                   abort;
    } ret_flags_t;

    function automatic logic [RAS_COST_W-1:0] ret_cost(input ret_kind_e k);
        case (k)
            RET_CORRECT: ret_cost = RAS_COST_W'(2);
            RET_MISPRED: ret_cost = RAS_COST_W'(9);
            default:     ret_cost = RAS_COST_W'(8);
        endcase
    endfunction

    function automatic ret_flags_t classify(input logic had_pred, input logic match);
        ret_flags_t f;
        if (!had_pred)   f.kind = RET_UNPRED;
        else if (match)  f.kind = RET_CORRECT;
        else             f.kind = RET_MISPRED;
        f.cost     = ret_cost(f.kind);
        f.redirect = (f.kind != RET_CORRECT);
        f.abort    = (f.kind == RET_MISPRED);
        return f;
    endfunction

endpackage

// File: rtl/ras_stack.sv
module ras_stack #(
    parameter int AW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_pc,
    input  logic          pop,
    output logic          top_valid,
    output logic [AW-1:0] top_pc
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PW-1:0]    top_q;
    logic [PW-1:0]    above;
    logic [PW-1:0]    below;
    logic [DEPTH-1:0] vld_q;
    logic [AW-1:0]    pc_q [DEPTH];
    logic             hit_pop;
    logic [PW-1:0]    wr_idx;
    logic             wr_en;

    assign above     = top_q + PW'(1);
    assign below     = top_q - PW'(1);
    assign top_valid = vld_q[top_q];
    assign top_pc    = pc_q[top_q];
    assign hit_pop   = pop && top_valid;

    // Pop and push together: the pushed PC overwrites the popped top slot.
    assign wr_en  = push;
    assign wr_idx = hit_pop ? top_q : above;

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
        end else if (hit_pop && !push) begin
            top_q <= below;
        end else if (push && !hit_pop) begin
            top_q <= above;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[i] <= 1'b0;
            end else if (wr_en && wr_idx == PW'(i)) begin
                vld_q[i] <= 1'b1;
            end else if (hit_pop && top_q == PW'(i)) begin
                vld_q[i] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == PW'(i)) begin
                pc_q[i] <= push_pc;
            end
        end
    end

endmodule

// File: rtl/ras_verify.sv
module ras_verify
    import ras_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ret_fetch,
    input  logic                  top_valid,
    input  logic [AW-1:0]         top_pc,
    input  logic                  verify_valid,
    input  logic [AW-1:0]         verify_addr,
    output logic                  res_valid,
    output ret_flags_t            res_flags,
    output logic [AW-1:0]         res_target
);
    logic          pend_q;
    logic          pend_hit_q;
    logic [AW-1:0] pend_pc_q;
    ret_flags_t    now_flags;

    assign now_flags = classify(pend_q && pend_hit_q, pend_pc_q == verify_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q     <= 1'b0;
            pend_hit_q <= 1'b0;
            pend_pc_q  <= '0;
        end else if (ret_fetch) begin
            pend_q     <= 1'b1;
            pend_hit_q <= top_valid;
            pend_pc_q  <= top_pc;
        end else if (verify_valid) begin
            pend_q     <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_flags  <= '0;
            res_target <= '0;
        end else begin
            res_valid <= verify_valid;
            if (verify_valid) begin
                res_flags  <= now_flags;
                res_target <= verify_addr;
            end
        end
    end

endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
    import ras_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  call_valid,
    input  logic [AW-1:0]         call_pc,
    input  logic                  ret_fetch,
    output logic                  pred_hit,
    output logic [AW-1:0]         pred_target,
    input  logic                  verify_valid,
    input  logic [AW-1:0]         verify_addr,
    output logic                  res_valid,
    output logic [1:0]            res_kind,
    output logic [RAS_COST_W-1:0] res_cost,
    output logic                  res_redirect,
    output logic                  res_abort,
    output logic [AW-1:0]         res_target
);
    logic          top_valid;
    logic [AW-1:0] top_pc;
    ret_flags_t    flags;

    ras_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (call_valid),
        .push_pc   (call_pc),
        .pop       (ret_fetch),
        .top_valid (top_valid),
        .top_pc    (top_pc)
    );

    ras_verify #(.AW(AW)) u_verify (
        .clk          (clk),
        .rst          (rst),
        .ret_fetch    (ret_fetch),
        .top_valid    (top_valid),
        .top_pc       (top_pc),
        .verify_valid (verify_valid),
        .verify_addr  (verify_addr),
        .res_valid    (res_valid),
        .res_flags    (flags),
        .res_target   (res_target)
    );

    assign pred_hit     = ret_fetch && top_valid;
    assign pred_target  = top_pc;
    assign res_kind     = flags.kind;
    assign res_cost     = flags.cost;
    assign res_redirect = flags.redirect;
    assign res_abort    = flags.abort;

endmodule

// File: rtl/ras_checker.sv
module ras_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          call_valid,
    input logic [AW-1:0] call_pc,
    input logic          ret_fetch,
    input logic          pred_hit,
    input logic [AW-1:0] pred_target,
    input logic          verify_valid,
    input logic [AW-1:0] verify_addr,
    input logic          res_valid,
    input logic [1:0]    res_kind,
    input logic [3:0]    res_cost,
    input logic          res_redirect,
    input logic          res_abort,
    input logic [AW-1:0] res_target
);
    logic          pushed_q;
    logic [AW-1:0] pushed_pc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pushed_q    <= 1'b0;
            pushed_pc_q <= '0;
        end else begin
            pushed_q    <= call_valid;
            pushed_pc_q <= call_pc;
        end
    end

    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) && ret_fetch |-> !pred_hit);

    assert_push_then_hit_R2: assert property (@(posedge clk) disable iff (rst)
        pushed_q && ret_fetch |-> pred_hit && pred_target == pushed_pc_q);

    assert_result_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        verify_valid |=> res_valid);

    assert_no_spurious_result_R7: assert property (@(posedge clk) disable iff (rst)
        !verify_valid |=> !res_valid);

    assert_correct_cost_R7: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_kind == 2'd0 |-> res_cost == 4'd2 && !res_redirect && !res_abort);

    assert_unpred_cost_R8: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_kind == 2'd1 |-> res_cost == 4'd8 && res_redirect && !res_abort);

    assert_target_from_memory_R8: assert property (@(posedge clk) disable iff (rst)
        verify_valid |=> res_target == $past(verify_addr));

    assert_abort_mispred_R9: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_abort |-> res_kind == 2'd2 && res_cost == 4'd9 && res_redirect);

    assert_kind_legal_R9: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> res_kind != 2'd3);

endmodule

bind ras_predictor ras_checker #(.AW(AW)) u_chk (.*);

// File: tb/sim_ras_predictor.sv
module sim_ras_predictor;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          call_valid;
    logic [AW-1:0] call_pc;
    logic          ret_fetch;
    logic          pred_hit;
    logic [AW-1:0] pred_target;
    logic          verify_valid;
    logic [AW-1:0] verify_addr;
    logic          res_valid;
    logic [1:0]    res_kind;
    logic [3:0]    res_cost;
    logic          res_redirect;
    logic          res_abort;
    logic [AW-1:0] res_target;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ras_predictor #(.AW(AW), .DEPTH(4)) u0 (.*);

    typedef struct packed {
        logic          call;
        logic [31:0]   cpc;
        logic          ret;
        logic          ver;
        logic [31:0]   vaddr;
        logic          ehit;
        logic [31:0]   etgt;
        logic          erv;
        logic [1:0]    ekind;
        logic [3:0]    ecost;
        logic          eredir;
        logic          eabort;
        logic [31:0]   eres;
    } vec_t;

    localparam int NV = 16;
    // res fields describe the verify of the previous row
    localparam vec_t TBL [NV] = '{
        '{1'b0, 32'h0,   1'b1, 1'b0, 32'h0,    1'b0, 32'h0,   1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 32'h0},    // R1
        '{1'b0, 32'h0,   1'b0, 1'b1, 32'h500,  1'b0, 32'h0,   1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h100, 1'b0, 1'b0, 32'h0,    1'b0, 32'h0,   1'b1, 2'd1, 4'd8, 1'b1, 1'b0, 32'h500},  // R8
        '{1'b1, 32'h200, 1'b0, 1'b0, 32'h0,    1'b0, 32'h0,   1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 32'h0},
        '{1'b1, 32'h300, 1'b0, 1'b0, 32'h0,    1'b0, 32'h0,   1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h0,   1'b1, 1'b0, 32'h0,    1'b1, 32'h300, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 32'h0},    // R2 R3
        '{1'b0, 32'h0,   1'b0, 1'b1, 32'h300,  1'b0, 32'h0,   1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h0,   1'b1, 1'b0, 32'h0,    1'b1, 32'h200, 1'b1, 2'd0, 4'd2, 1'b0, 1'b0, 32'h300},  // R3 R7
        '{1'b1, 32'h400, 1'b0, 1'b1, 32'h9999, 1'b0, 32'h0,   1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 32'h0},    // R10
        '{1'b0, 32'h0,   1'b1, 1'b0, 32'h0,    1'b1, 32'h400, 1'b1, 2'd2, 4'd9, 1'b1, 1'b1, 32'h9999}, // R9 R10
        '{1'b1, 32'h500, 1'b1, 1'b0, 32'h0,    1'b1, 32'h100, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 32'h0},    // R6
        '{1'b0, 32'h0,   1'b1, 1'b0, 32'h0,    1'b1, 32'h500, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 32'h0},    // R6
        '{1'b0, 32'h0,   1'b1, 1'b0, 32'h0,    1'b0, 32'h0,   1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 32'h0},    // R5
        '{1'b1, 32'h600, 1'b0, 1'b0, 32'h0,    1'b0, 32'h0,   1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 32'h0},
        '{1'b0, 32'h0,   1'b1, 1'b0, 32'h0,    1'b1, 32'h600, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 32'h0},    // R5
        '{1'b0, 32'h0,   1'b1, 1'b0, 32'h0,    1'b0, 32'h0,   1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 32'h0}     // R5
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic [31:0] cp, input logic r,
                         input logic v, input logic [31:0] va);
        call_valid   = c;
        call_pc      = cp;
        ret_fetch    = r;
        verify_valid = v;
        verify_addr  = va;
    endtask

    task automatic pop_expect(input logic ehit, input logic [31:0] etgt, input string req);
        @(negedge clk);
        drive(1'b0, 32'h0, 1'b1, 1'b0, 32'h0);
        #2;
        chk(pred_hit == ehit, req, "pred_hit", 64'(pred_hit), 64'(ehit));
        if (ehit) chk(pred_target == etgt, req, "pred_target", 64'(pred_target), 64'(etgt));
    endtask

    task automatic push_one(input logic [31:0] pc);
        @(negedge clk);
        drive(1'b1, pc, 1'b0, 1'b0, 32'h0);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk(res_valid == 1'b0, "R1", "res_valid after reset", 64'(res_valid), 64'd0);
        chk(res_redirect == 1'b0 && res_abort == 1'b0, "R1", "res flags after reset",
            64'({res_redirect, res_abort}), 64'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = TBL[i];
            @(negedge clk);
            drive(v.call, v.cpc, v.ret, v.ver, v.vaddr);
            #2;
            if (v.ret) begin
                chk(pred_hit == v.ehit, $sformatf("row%0d R2/R3/R5/R6", i), "pred_hit",
                    64'(pred_hit), 64'(v.ehit));
                if (v.ehit)
                    chk(pred_target == v.etgt, $sformatf("row%0d R2/R3/R6", i), "pred_target",
                        64'(pred_target), 64'(v.etgt));
            end
            chk(res_valid == v.erv, $sformatf("row%0d R7", i), "res_valid",
                64'(res_valid), 64'(v.erv));
            if (v.erv) begin
                chk(res_kind == v.ekind && res_cost == v.ecost,
                    $sformatf("row%0d R7/R8/R9/R10", i), "kind,cost",
                    64'({res_kind, res_cost}), 64'({v.ekind, v.ecost}));
                chk(res_redirect == v.eredir && res_abort == v.eabort,
                    $sformatf("row%0d R8/R9", i), "redirect,abort",
                    64'({res_redirect, res_abort}), 64'({v.eredir, v.eabort}));
                chk(res_target == v.eres, $sformatf("row%0d R8/R9", i), "res_target",
                    64'(res_target), 64'(v.eres));
            end
        end

        // R4: overflow keeps the four newest
        push_one(32'hA1);
        push_one(32'hA2);
        push_one(32'hA3);
        push_one(32'hA4);
        push_one(32'hA5);
        pop_expect(1'b1, 32'hA5, "R4");
        pop_expect(1'b1, 32'hA4, "R4");
        pop_expect(1'b1, 32'hA3, "R4");
        pop_expect(1'b1, 32'hA2, "R4");
        pop_expect(1'b0, 32'h0,  "R4");

        // R9 again with a deeper stack, then R1 reset clears entries
        push_one(32'hB1);
        push_one(32'hB2);
        pop_expect(1'b1, 32'hB2, "R3");
        @(negedge clk);
        drive(1'b0, 32'h0, 1'b0, 1'b1, 32'hB3);
        @(negedge clk);
        drive(1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
        #2;
        chk(res_valid && res_abort && res_kind == 2'd2 && res_cost == 4'd9, "R9",
            "mispredict result", 64'({res_valid, res_abort, res_kind, res_cost}),
            64'({1'b1, 1'b1, 2'd2, 4'd9}));
        chk(res_target == 32'hB3, "R9", "res_target", 64'(res_target), 64'h0B3);
        @(negedge clk);
        #2;
        chk(res_valid == 1'b0, "R7", "single-cycle res_valid", 64'(res_valid), 64'd0);

        // R8: verify with no pending return
        @(negedge clk);
        drive(1'b0, 32'h0, 1'b0, 1'b1, 32'hC0);
        @(negedge clk);
        drive(1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
        #2;
        chk(res_kind == 2'd1 && res_cost == 4'd8 && res_redirect && !res_abort, "R8",
            "no pending return", 64'({res_kind, res_cost}), 64'({2'd1, 4'd8}));

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        pop_expect(1'b0, 32'h0, "R1");

        @(negedge clk);
        drive(1'b0, 32'h0, 1'b0, 1'b0, 32'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule